// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block runs the pins of a small serial EEPROM that holds 64 words of 16 bits. It drives chip select, shift clock and data-in, and it reads the device's data-out line. A host hands it one command at a time: either a word read or a word write, with a 6-bit word address and, for writes, 16 bits of data. When the command has finished, the block pulses a done strobe. For a read, the strobe carries the word that came back. For a write, it carries a flag that says whether the device failed to report completion in time.

Every pin level is held for a whole bit period. The `TICK_CLKS` parameter sets that period as a number of system clocks. A write runs as a fixed sequence. First it unlocks the device with an enable frame. Then it sends the write frame and toggles chip select to start the internal programming. Next it polls data-out for the ready level, giving up after `POLL_LIMIT` samples. Finally it locks the device again with a disable frame.

The command port is valid/ready. `cmd_ready` is high only while the block is idle. A command is taken on the rising clock edge where `cmd_valid` and `cmd_ready` are both high, and its fields are captured at that same edge. While the block is busy, `cmd_ready` stays low, so the host must hold its command until the block is idle again. The response side is a plain one-cycle pulse and offers no back-pressure.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While idle, `cmd_ready` is 1, all three output pins are 0 and `rsp_valid` is 0. The edge that accepts a command drops `cmd_ready` to 0, and it stays 0 until the done cycle.
- R2: A command opens with one period of chip select, clock and data-in all 0, followed by one period with only chip select at 1.
- R3: Each transmitted bit goes out MSB first and takes three periods, with chip select at 1 and data-in equal to the bit throughout: clock 0, then clock 1, then clock 0. After the last bit of a frame comes one period with data-in at 0 and clock at 0.
- R4: A read sends the 9-bit header made of opcode 110 followed by the 6-bit address. It then runs 16 input bits with data-in at 0, each bit being one period of clock 1 followed by one period of clock 0. Data-out is sampled at the end of the clock-1 period, and the first bit sampled is bit 15 of `rsp_rdata`. A read returns `rsp_timeout` = 0.
- R5: A write first sends the enable frame 10011 followed by four 0 bits, then a standby toggle. After that it sends the 25-bit frame made of opcode 101, the 6-bit address and the 16 data bits.
- R6: A standby toggle lasts four periods, with data-in at 0 throughout. The (chip select, clock) pair takes the values (0,0), then (0,1), then (1,1), then (1,0).
- R7: After the write frame, a standby toggle is followed by poll periods with chip select at 1 and clock at 0. Data-out is sampled at the end of each poll period, and the first sample that reads 1 ends the poll. If the 1 arrives on sample number `POLL_LIMIT` itself, `rsp_timeout` is still 0.
- R8: If `POLL_LIMIT` samples all read 0, the write still completes the rest of its sequence and reports `rsp_timeout` = 1. A write reports `rsp_rdata` = 0. Both response fields hold their values between done pulses.
- R9: After the poll, a write gives a standby toggle and then the disable frame 10000 followed by four 0 bits.
- R10: A command closes with three periods of chip select 0 and data-in 0, during which the clock goes 0, then 1, then 0. In the next cycle `rsp_valid` is 1 for exactly one cycle, with all pins at 0 and `cmd_ready` at 1.
- R11: Every pin step lasts exactly `TICK_CLKS` system clocks. Data-in never changes while the clock stays high from one cycle to the next.
- R12: A command that is valid during the done cycle is accepted at the edge that ends that cycle, so its opening period begins in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = word write, 0 = word read |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Data for a write |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_rdata | output | 16 | Word read back (0 after a write) |
| rsp_timeout | output | 1 | Write saw no ready within the poll limit |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data and ready level from the EEPROM |

## Verification
The done strobe of one command and the acceptance of the next can land in the same cycle. The bench provokes this by presenting a new command in the done cycle itself: a read straight after a write that timed out, and then a write straight after that read. The judgement has two parts. First, the new command's opening period must begin in the next cycle. Second, the flag from the earlier write must not leak into the later response. A second collision occurs inside the poll, where the ready level and the last allowed sample coincide. The bench raises data-out exactly on sample `POLL_LIMIT` and expects completion without the timeout flag.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_SETUP,
    SEG_SHOUT,
    SEG_SHIN,
    SEG_STBY,
    SEG_POLL,
    SEG_CLEAN
  } seg_e;

  localparam logic [2:0] OP_RD   = 3'b110;
  localparam logic [2:0] OP_WR   = 3'b101;
  localparam logic [4:0] OP_WEN  = 5'b10011;
  localparam logic [4:0] OP_WDIS = 5'b10000;

  // Segment program: read = setup, header, data in, close
  // write = setup, enable, toggle, frame, toggle, poll, toggle, disable, close
  function automatic seg_e seg_at(input logic wr, input logic [3:0] pc);
    seg_e s;
    s = SEG_IDLE;
    if (!wr) begin
      case (pc)
        4'd0: s = SEG_SETUP;
        4'd1: s = SEG_SHOUT;
        4'd2: s = SEG_SHIN;
        4'd3: s = SEG_CLEAN;
        default: s = SEG_IDLE;
      endcase
    end else begin
      case (pc)
        4'd0: s = SEG_SETUP;
        4'd1: s = SEG_SHOUT;
        4'd2: s = SEG_STBY;
        4'd3: s = SEG_SHOUT;
        4'd4: s = SEG_STBY;
        4'd5: s = SEG_POLL;
        4'd6: s = SEG_STBY;
        4'd7: s = SEG_SHOUT;
        4'd8: s = SEG_CLEAN;
        default: s = SEG_IDLE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/uwe_tick.sv
module uwe_tick #(
  parameter int TICK_CLKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(TICK_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/uwe_shifter.sv
module uwe_shifter #(
  parameter int SR_W  = 25,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SR_W-1:0]  load_val,
  input  logic             shift,
  input  logic             in_bit,
  output logic             msb,
  output logic [OUT_W-1:0] tail
);
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (shift) begin
      sr_q <= {sr_q[SR_W-2:0], in_bit};
    end
  end

  assign msb  = sr_q[SR_W-1];
  assign tail = sr_q[OUT_W-1:0];
endmodule

// File: rtl/uwe_seq.sv
module uwe_seq
  import uwe_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int POLL_LIMIT = 200,
  parameter int SR_W       = 3 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              tick,
  input  logic              ee_do,
  input  logic              sr_msb,
  input  logic [DATA_W-1:0] sr_tail,
  output logic              sr_load,
  output logic [SR_W-1:0]   sr_load_val,
  output logic              sr_shift,
  output logic              sr_in_bit,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout
);
  localparam int HDR_W  = 3 + ADDR_W;
  localparam int LEN_W  = $clog2(SR_W + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  seg_e              seg_q, nxt_seg;
  logic [3:0]        pc_q, pc_n;
  logic [1:0]        step_q;
  logic [LEN_W-1:0]  bits_q;
  logic              tail_q;
  logic [POLL_W-1:0] polls_q;
  logic              wr_q, timeout_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              last;
  logic              rsp_valid_q, rsp_timeout_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  function automatic logic [SR_W-1:0] frame_val(input logic wr, input logic [3:0] pc,
                                                input logic [ADDR_W-1:0] a,
                                                input logic [DATA_W-1:0] d);
    logic [SR_W-1:0] v;
    v = '0;
    if (!wr) v = {OP_RD, a, {DATA_W{1'b0}}};
    else if (pc == 4'd1) v = {OP_WEN, {(SR_W-5){1'b0}}};
    else if (pc == 4'd3) v = {OP_WR, a, d};
    else v = {OP_WDIS, {(SR_W-5){1'b0}}};
    return v;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic wr, input logic [3:0] pc);
    return (wr && pc == 4'd3) ? LEN_W'(SR_W) : LEN_W'(HDR_W);
  endfunction

  always_comb begin
    case (seg_q)
      SEG_SETUP: last = (step_q == 2'd1);
      SEG_STBY:  last = (step_q == 2'd3);
      SEG_CLEAN: last = (step_q == 2'd2);
      SEG_SHOUT: last = tail_q;
      SEG_SHIN:  last = (step_q == 2'd1) && (bits_q == LEN_W'(1));
      SEG_POLL:  last = ee_do || (polls_q == POLL_LAST);
      default:   last = 1'b0;
    endcase
  end

  assign pc_n        = pc_q + 4'd1;
  assign nxt_seg     = seg_at(wr_q, pc_n);
  assign sr_load     = tick && last && (nxt_seg == SEG_SHOUT) && (seg_q != SEG_CLEAN);
  assign sr_load_val = frame_val(wr_q, pc_n, addr_q, data_q);
  assign sr_shift    = tick && ((seg_q == SEG_SHOUT && !tail_q && step_q == 2'd2) ||
                                (seg_q == SEG_SHIN && step_q == 2'd0));
  assign sr_in_bit   = ee_do;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q         <= SEG_IDLE;
      pc_q          <= '0;
      step_q        <= '0;
      bits_q        <= '0;
      tail_q        <= 1'b0;
      polls_q       <= '0;
      wr_q          <= 1'b0;
      timeout_q     <= 1'b0;
      addr_q        <= '0;
      data_q        <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_rdata_q   <= '0;
      rsp_timeout_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (seg_q == SEG_IDLE) begin
        if (cmd_valid) begin
          seg_q     <= SEG_SETUP;
          pc_q      <= '0;
          step_q    <= '0;
          wr_q      <= cmd_write;
          addr_q    <= cmd_addr;
          data_q    <= cmd_wdata;
          timeout_q <= 1'b0;
        end
      end else if (tick) begin
        if (last) begin
          step_q  <= '0;
          tail_q  <= 1'b0;
          polls_q <= '0;
          if (seg_q == SEG_POLL && !ee_do) timeout_q <= 1'b1;
          if (seg_q == SEG_CLEAN) begin
            seg_q         <= SEG_IDLE;
            rsp_valid_q   <= 1'b1;
            rsp_rdata_q   <= wr_q ? '0 : sr_tail;
            rsp_timeout_q <= timeout_q;
          end else begin
            seg_q  <= nxt_seg;
            pc_q   <= pc_n;
            bits_q <= (nxt_seg == SEG_SHOUT) ? frame_len(wr_q, pc_n) : LEN_W'(DATA_W);
          end
        end else begin
          case (seg_q)
            SEG_SHOUT: begin
              if (step_q == 2'd2) begin
                step_q <= '0;
                bits_q <= bits_q - LEN_W'(1);
                if (bits_q == LEN_W'(1)) tail_q <= 1'b1;
              end else begin
                step_q <= step_q + 2'd1;
              end
            end
            SEG_SHIN: begin
              if (step_q == 2'd1) begin
                step_q <= '0;
                bits_q <= bits_q - LEN_W'(1);
              end else begin
                step_q <= 2'd1;
              end
            end
            SEG_POLL: polls_q <= polls_q + POLL_W'(1);
            default:  step_q <= step_q + 2'd1;
          endcase
        end
      end
    end
  end

  always_comb begin
    ee_cs = 1'b0;
    ee_sk = 1'b0;
    ee_di = 1'b0;
    case (seg_q)
      SEG_SETUP: ee_cs = (step_q == 2'd1);
      SEG_SHOUT: begin
        ee_cs = 1'b1;
        ee_sk = !tail_q && (step_q == 2'd1);
        ee_di = !tail_q && sr_msb;
      end
      SEG_SHIN: begin
        ee_cs = 1'b1;
        ee_sk = (step_q == 2'd0);
      end
      SEG_STBY: begin
        ee_cs = step_q[1];
        ee_sk = (step_q == 2'd1) || (step_q == 2'd2);
      end
      SEG_POLL:  ee_cs = 1'b1;
      SEG_CLEAN: ee_sk = (step_q == 2'd1);
      default: ;
    endcase
  end

  assign cmd_ready   = (seg_q == SEG_IDLE);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign rsp_timeout = rsp_timeout_q;
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master #(
  parameter int TICK_CLKS  = 2500,
  parameter int POLL_LIMIT = 200,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int SR_W = 3 + ADDR_W + DATA_W;

  logic              tick;
  logic              sr_load, sr_shift, sr_in_bit, sr_msb;
  logic [SR_W-1:0]   sr_load_val;
  logic [DATA_W-1:0] sr_tail;

  uwe_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!cmd_ready),
    .tick (tick)
  );

  uwe_shifter #(.SR_W(SR_W), .OUT_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sr_load),
    .load_val(sr_load_val),
    .shift   (sr_shift),
    .in_bit  (sr_in_bit),
    .msb     (sr_msb),
    .tail    (sr_tail)
  );

  uwe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT), .SR_W(SR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .cmd_ready  (cmd_ready),
    .tick       (tick),
    .ee_do      (ee_do),
    .sr_msb     (sr_msb),
    .sr_tail    (sr_tail),
    .sr_load    (sr_load),
    .sr_load_val(sr_load_val),
    .sr_shift   (sr_shift),
    .sr_in_bit  (sr_in_bit),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .ee_di      (ee_di),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_timeout(rsp_timeout)
  );
endmodule

// File: rtl/uwe_checker.sv
module uwe_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_timeout,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);
  a_r1_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ee_cs && !ee_sk && !ee_di));

  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);

  a_r11_di_steady_sk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r8_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_timeout));

  a_r4_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));
endmodule

bind uwire_eeprom_master uwe_checker #(.DATA_W(DATA_W)) u_uwe_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_timeout(rsp_timeout),
  .ee_cs      (ee_cs),
  .ee_sk      (ee_sk),
  .ee_di      (ee_di)
);

// File: tb/uwire_eeprom_master_bench.sv
module uwire_eeprom_master_bench;
  localparam int TICK  = 3;
  localparam int POLLS = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        ee_do = 1'b0;
  logic        cmd_ready, rsp_valid, rsp_timeout, ee_cs, ee_sk, ee_di;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  uwire_eeprom_master #(.TICK_CLKS(TICK), .POLL_LIMIT(POLLS)) u_uwire_eeprom_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // one pin step: {cs, sk, di, value driven on data-out}, held for TICK clocks
  task automatic put(input logic cs, input logic sk, input logic di, input logic d,
                     input string t);
    repeat (TICK) begin
      q_exp.push_back({cs, sk, di, d});
      q_tag.push_back(t);
    end
  endtask

  task automatic put_frame(input logic [31:0] v, input int n, input string t);
    for (int i = n - 1; i >= 0; i--) begin
      put(1'b1, 1'b0, v[i], 1'b0, t);
      put(1'b1, 1'b1, v[i], 1'b0, t);
      put(1'b1, 1'b0, v[i], 1'b0, t);
    end
    put(1'b1, 1'b0, 1'b0, 1'b0, t);
  endtask

  task automatic put_stby();
    put(1'b0, 1'b0, 1'b0, 1'b0, "R6 standby");
    put(1'b0, 1'b1, 1'b0, 1'b0, "R6 standby");
    put(1'b1, 1'b1, 1'b0, 1'b0, "R6 standby");
    put(1'b1, 1'b0, 1'b0, 1'b0, "R6 standby");
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk({ee_cs, ee_sk, ee_di, cmd_ready, rsp_valid} === 5'b00010, "R1",
          "idle pins/ready/done", {ee_cs, ee_sk, ee_di, cmd_ready, rsp_valid}, 5'b00010);
    end
  endtask

  // k: poll sample on which data-out goes high (1..POLLS), 0 = never
  task automatic run(input bit wr, input logic [5:0] a, input logic [15:0] d,
                     input logic [15:0] rd, input int k);
    logic [3:0] e;
    string t;
    logic [4:0] act;
    int n;
    q_exp.delete();
    q_tag.delete();
    put(1'b0, 1'b0, 1'b0, 1'b0, "R2 setup");
    put(1'b1, 1'b0, 1'b0, 1'b0, "R2 setup");
    if (!wr) begin
      put_frame({23'd0, 3'b110, a}, 9, "R3,R4 read header");
      for (int i = 15; i >= 0; i--) begin
        put(1'b1, 1'b1, 1'b0, rd[i], "R4 read data");
        put(1'b1, 1'b0, 1'b0, rd[i], "R4 read data");
      end
    end else begin
      put_frame(32'b1_0011_0000, 9, "R5 enable frame");
      put_stby();
      put_frame({7'd0, 3'b101, a, d}, 25, "R3,R5 write frame");
      put_stby();
      n = (k == 0) ? POLLS : k;
      for (int j = 0; j < n; j++) put(1'b1, 1'b0, 1'b0, (j == k - 1), "R7 poll");
      put_stby();
      put_frame(32'b1_0000_0000, 9, "R9 disable frame");
    end
    put(1'b0, 1'b0, 1'b0, 1'b0, "R10 close");
    put(1'b0, 1'b1, 1'b0, 1'b0, "R10 close");
    put(1'b0, 1'b0, 1'b0, 1'b0, "R10 close");

    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr  = a;
    cmd_wdata = d;
    chk(cmd_ready === 1'b1, "R1", "ready before accept", cmd_ready, 1);
    @(posedge clk);
    while (q_exp.size() > 0) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      ee_do = e[0];
      act = {ee_cs, ee_sk, ee_di, cmd_ready, rsp_valid};
      chk(act === {e[3:1], 2'b00}, t, "R11 per-cycle pins/ready/done", act, {e[3:1], 2'b00});
    end
    @(negedge clk);
    ee_do = 1'b0;
    act = {ee_cs, ee_sk, ee_di, cmd_ready, rsp_valid};
    chk(act === 5'b00011, "R10", "done cycle pins/ready/done", act, 5'b00011);
    chk(rsp_rdata === (wr ? 16'h0 : rd), "R4", "response data", rsp_rdata, wr ? 16'h0 : rd);
    chk(rsp_timeout === (wr && k == 0), "R8", "timeout flag", rsp_timeout, (wr && k == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, rsp_valid} === 4'b0000, "R1", "reset pins/done",
        {ee_cs, ee_sk, ee_di, rsp_valid}, 0);
    rst_n = 1'b1;
    idle(2);
    run(1'b0, 6'h2A, 16'h0, 16'hC3A5, 0);
    idle(3);
    run(1'b0, 6'h3F, 16'h0, 16'hFFFF, 0);
    idle(1);
    run(1'b0, 6'h00, 16'h0, 16'h0001, 0);
    idle(2);
    run(1'b1, 6'h05, 16'h1234, 16'h0, 1);
    idle(2);
    run(1'b1, 6'h3F, 16'hBEEF, 16'h0, 7);
    idle(2);
    run(1'b1, 6'h11, 16'h8001, 16'h0, POLLS);   // R7 ready on the last allowed sample
    idle(2);
    run(1'b1, 6'h2B, 16'h5AA5, 16'h0, 0);       // R8 never ready
    // R12: next command presented in the done cycle
    run(1'b0, 6'h15, 16'h0, 16'h6D2B, 0);
    run(1'b1, 6'h00, 16'hFFFF, 16'h0, 3);       // R12 again, write after read
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule